// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block moves received frames into system memory through up to four rings of linked receive descriptors. Software builds each ring as a closed chain of 16-byte descriptors. It hands a descriptor to the engine by setting the descriptor's ownership bit, and it points the engine at a ring through a per-ring pointer register. When a frame header arrives carrying a length, the engine looks for a descriptor it owns whose buffer is large enough. It copies the frame bytes into that buffer and writes the byte count back. It then returns the descriptor to software and raises an interrupt cause bit.

The engine handles one frame at a time. The search visits the rings in ascending index order. Within a ring it starts at the ring's current pointer and follows the next links. It gives up on that ring as soon as a link leads back to the ring's head. A frame that finds no descriptor is read from the stream and discarded. All descriptor and buffer traffic goes through a single 32-bit memory master port with a request/grant handshake.

Top module: `rxd_dma`

## Requirements
- R1: Descriptors are 16 bytes and little-endian, with four words read in this order:
  - +0 is the control word, and bit 31 is the ownership bit.
  - +4 holds the byte count in bits 15:0 and the buffer capacity in bits 31:16.
  - +8 is the buffer address.
  - +12 is the next-descriptor address.
- R2: Rings are searched from index 0 upward, and a ring whose current pointer is zero is passed over.
- R3: A descriptor takes the frame only if its ownership bit is 1 and its capacity is greater than or equal to the frame length; equality is accepted.
- R4: Frame byte i goes to address buffer + offset + i, one byte lane per write. The word at +4 is rewritten with the capacity unchanged and the count set to length + offset. The offset comes from register word 2, bits 1:0.
- R5: On acceptance the control word is written back with bit 31 cleared, and the ring's current pointer becomes the descriptor's next address.
- R6: A rejected descriptor sends the search to its next address. When that address equals the ring head, the search leaves the ring, even if the head descriptor is owned.
- R7: A frame that no descriptor takes is consumed byte by byte and dropped. Memory, ring pointers and the cause bit are left unchanged.
- R8: Each accepted frame sets cause bit 0 (register word 0). Writing 1 to that bit clears it, and writing 0 has no effect. The mask is register word 1, bit 0, and irq equals cause AND mask.
- R9: Register map and read-back:
  - Writing ring pointer word 4+r loads both the head and the current pointer of ring r, and reading that word returns the current pointer.
  - Words 8+r hold a first-descriptor value per ring, which reads back as written.
  - All registers reset to 0.
- R10: hdr_ready is high only when the engine is idle, and in_ready is high only while the engine waits for a frame byte. The two are never high together, and a frame header cannot be taken while a frame is in progress.
- R11: A memory request holds its address, direction and data steady until mem_gnt. Read data is taken in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| hdr_valid | input | 1 | Frame header valid |
| hdr_len | input | 16 | Frame length in bytes |
| hdr_ready | output | 1 | Engine idle, header accepted |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_ready | output | 1 | Engine takes a byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_gnt |
| irq | output | 1 | Interrupt, cause AND mask |

## Verification
The hardest case to reach is a ring whose current pointer has moved past the head. In that case the walk stops when it wraps back to the head, even though the head descriptor is owned and large enough. To reach it, the stimulus first advances a three-descriptor ring by one accepted frame. It then revokes ownership of the other two descriptors and re-grants the head behind the engine's back. The next frame must then be dropped. Capacity equal to the frame length, zero-length frames with a header offset, and a ring reloaded through its pointer register are each driven as separate frames. Memory grants are withheld on a repeating pattern so that requests are held across stalls.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_PICK, S_RD0, S_RD1, S_RD2, S_RD3, S_CHK,
      S_DIN, S_DWR, S_WB0, S_WB1, S_DROP
   } rxd_st_t;
   localparam int OWN_BIT = 31;
   localparam int GRP_CTL = 0;
   localparam int GRP_PTR = 1;
   localparam int GRP_FST = 2;
endpackage

// File: rtl/rxd_regs.sv
module rxd_regs #(
   parameter int NR    = 4,
   parameter int OFS_W = 2,
   parameter int RW    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [3:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 upd_en,
   input  logic [RW-1:0]        upd_ring,
   input  logic [31:0]          upd_next,
   output logic [NR-1:0][31:0]  head,
   output logic [NR-1:0][31:0]  cur,
   output logic [OFS_W-1:0]     ofs,
   output logic                 irq
);
   import rxd_pkg::*;
   logic [1:0] grp, idx;
   logic cause, mask;
   logic [NR-1:0][31:0] first;

   assign grp = reg_addr[3:2];
   assign idx = reg_addr[1:0];
   assign irq = cause & mask;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cause <= 1'b0;
         mask  <= 1'b0;
         ofs   <= '0;
      end else begin
         if (upd_en)
            cause <= 1'b1;
         else if (reg_we && grp == 2'(GRP_CTL) && idx == 2'd0 && reg_wdata[0])
            cause <= 1'b0;
         if (reg_we && grp == 2'(GRP_CTL) && idx == 2'd1) mask <= reg_wdata[0];
         if (reg_we && grp == 2'(GRP_CTL) && idx == 2'd2) ofs  <= reg_wdata[OFS_W-1:0];
      end
   end

   for (genvar r = 0; r < NR; r++) begin : g_ring
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            head[r]  <= '0;
            cur[r]   <= '0;
            first[r] <= '0;
         end else begin
            if (reg_we && grp == 2'(GRP_PTR) && idx == 2'(r)) begin
               head[r] <= reg_wdata;
               cur[r]  <= reg_wdata;
            end else if (upd_en && upd_ring == RW'(r)) begin
               cur[r]  <= upd_next;
            end
            if (reg_we && grp == 2'(GRP_FST) && idx == 2'(r))
               first[r] <= reg_wdata;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (grp)
         2'(GRP_CTL): begin
            if (idx == 2'd0) reg_rdata = {31'd0, cause};
            if (idx == 2'd1) reg_rdata = {31'd0, mask};
            if (idx == 2'd2) reg_rdata = 32'(ofs);
         end
         2'(GRP_PTR): for (int i = 0; i < NR; i++) if (idx == 2'(i)) reg_rdata = cur[i];
         2'(GRP_FST): for (int i = 0; i < NR; i++) if (idx == 2'(i)) reg_rdata = first[i];
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/rxd_walker.sv
module rxd_walker #(
   parameter int NR    = 4,
   parameter int OFS_W = 2,
   parameter int RW    = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 hdr_valid,
   input  logic [15:0]          hdr_len,
   output logic                 hdr_ready,
   input  logic                 in_valid,
   input  logic [7:0]           in_data,
   output logic                 in_ready,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [31:0]          mem_addr,
   output logic [3:0]           mem_be,
   output logic [31:0]          mem_wdata,
   input  logic                 mem_gnt,
   input  logic [31:0]          mem_rdata,
   input  logic [NR-1:0][31:0]  head,
   input  logic [NR-1:0][31:0]  cur,
   input  logic [OFS_W-1:0]     ofs,
   output logic                 upd_en,
   output logic [RW-1:0]        upd_ring,
   output logic [31:0]          upd_next
);
   import rxd_pkg::*;
   rxd_st_t st;
   logic [RW-1:0] ring;
   logic [31:0] dptr, cmd, buf_a, nxt, cur_sel, head_sel, wa;
   logic [15:0] bsize, flen, cnt, cnt_nx;
   logic [7:0]  dbyte;
   logic        take;

   always_comb begin
      cur_sel  = '0;
      head_sel = '0;
      for (int i = 0; i < NR; i++)
         if (ring == RW'(i)) begin
            cur_sel  = cur[i];
            head_sel = head[i];
         end
   end

   assign take     = cmd[OWN_BIT] && (bsize >= flen);
   assign cnt_nx   = cnt + 16'd1;
   assign wa       = buf_a + 32'(ofs) + 32'(cnt);
   assign hdr_ready = (st == S_IDLE);
   assign in_ready  = (st == S_DIN) || (st == S_DROP);
   assign upd_en    = (st == S_WB1) && mem_gnt;
   assign upd_ring  = ring;
   assign upd_next  = nxt;

   always_comb begin
      mem_req   = 1'b1;
      mem_we    = 1'b0;
      mem_be    = 4'hF;
      mem_addr  = dptr;
      mem_wdata = '0;
      case (st)
         S_RD0: mem_addr = dptr;
         S_RD1: mem_addr = dptr + 32'd4;
         S_RD2: mem_addr = dptr + 32'd8;
         S_RD3: mem_addr = dptr + 32'd12;
         S_DWR: begin
            mem_we    = 1'b1;
            mem_addr  = {wa[31:2], 2'b00};
            mem_be    = 4'b0001 << wa[1:0];
            mem_wdata = {4{dbyte}};
         end
         S_WB0: begin
            mem_we    = 1'b1;
            mem_addr  = dptr + 32'd4;
            mem_wdata = {bsize, flen + 16'(ofs)};
         end
         S_WB1: begin
            mem_we    = 1'b1;
            mem_wdata = cmd & ~(32'd1 << OWN_BIT);
         end
         default: mem_req = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= S_IDLE; ring <= '0; dptr <= '0; cmd <= '0; buf_a <= '0;
         nxt <= '0; bsize <= '0; flen <= '0; cnt <= '0; dbyte <= '0;
      end else begin
         case (st)
            S_IDLE: if (hdr_valid) begin
               flen <= hdr_len; ring <= '0; cnt <= '0; st <= S_PICK;
            end
            S_PICK: begin
               if (ring == RW'(NR))
                  st <= (flen == 16'd0) ? S_IDLE : S_DROP;
               else if (cur_sel == 32'd0)
                  ring <= ring + RW'(1);
               else begin
                  dptr <= cur_sel; st <= S_RD0;
               end
            end
            S_RD0: if (mem_gnt) begin cmd   <= mem_rdata;         st <= S_RD1; end
            S_RD1: if (mem_gnt) begin bsize <= mem_rdata[31:16];  st <= S_RD2; end
            S_RD2: if (mem_gnt) begin buf_a <= mem_rdata;         st <= S_RD3; end
            S_RD3: if (mem_gnt) begin nxt   <= mem_rdata;         st <= S_CHK; end
            S_CHK: begin
               if (take)
                  st <= (flen == 16'd0) ? S_WB0 : S_DIN;
               else if (nxt == head_sel) begin
                  ring <= ring + RW'(1); st <= S_PICK;
               end else begin
                  dptr <= nxt; st <= S_RD0;
               end
            end
            S_DIN: if (in_valid) begin dbyte <= in_data; st <= S_DWR; end
            S_DWR: if (mem_gnt) begin
               cnt <= cnt_nx;
               st  <= (cnt_nx == flen) ? S_WB0 : S_DIN;
            end
            S_WB0: if (mem_gnt) st <= S_WB1;
            S_WB1: if (mem_gnt) st <= S_IDLE;
            S_DROP: if (in_valid) begin
               cnt <= cnt_nx;
               if (cnt_nx == flen) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rxd_dma.sv
module rxd_dma #(
   parameter int NUM_RINGS = 4,
   parameter int OFS_W     = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [3:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        hdr_valid,
   input  logic [15:0] hdr_len,
   output logic        hdr_ready,
   input  logic        in_valid,
   input  logic [7:0]  in_data,
   output logic        in_ready,
   output logic        mem_req,
   output logic        mem_we,
   output logic [31:0] mem_addr,
   output logic [3:0]  mem_be,
   output logic [31:0] mem_wdata,
   input  logic        mem_gnt,
   input  logic [31:0] mem_rdata,
   output logic        irq
);
   localparam int RW = $clog2(NUM_RINGS + 1);

   if (NUM_RINGS < 1 || NUM_RINGS > 4) begin : g_bad_rings
      $error("rxd_dma: NUM_RINGS must be 1..4");
   end
   if (OFS_W < 1 || OFS_W > 8) begin : g_bad_ofs
      $error("rxd_dma: OFS_W must be 1..8");
   end

   logic [NUM_RINGS-1:0][31:0] head, cur;
   logic [OFS_W-1:0] ofs;
   logic             upd_en;
   logic [RW-1:0]    upd_ring;
   logic [31:0]      upd_next;

   rxd_regs #(.NR(NUM_RINGS), .OFS_W(OFS_W), .RW(RW)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_en(upd_en),
      .upd_ring(upd_ring), .upd_next(upd_next), .head(head), .cur(cur),
      .ofs(ofs), .irq(irq));

   rxd_walker #(.NR(NUM_RINGS), .OFS_W(OFS_W), .RW(RW)) u_walk (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_len(hdr_len),
      .hdr_ready(hdr_ready), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .head(head), .cur(cur),
      .ofs(ofs), .upd_en(upd_en), .upd_ring(upd_ring), .upd_next(upd_next));
endmodule

// File: rtl/rxd_dma_chk.sv
module rxd_dma_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_we,
   input logic        hdr_valid,
   input logic        hdr_ready,
   input logic        in_ready,
   input logic        mem_req,
   input logic        mem_we,
   input logic [31:0] mem_addr,
   input logic [3:0]  mem_be,
   input logic [31:0] mem_wdata,
   input logic        mem_gnt,
   input logic        irq
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11
   AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hdr_ready && in_ready)); // R10
   AST_HDR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_valid && hdr_ready) |=> !hdr_ready); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_ready |-> !mem_req); // R10
   AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(reg_we)); // R8
   AST_WR_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_be != 4'h0)); // R4
endmodule

bind rxd_dma rxd_dma_chk u_chk (
   .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .hdr_valid(hdr_valid),
   .hdr_ready(hdr_ready), .in_ready(in_ready), .mem_req(mem_req),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
   .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .irq(irq));

// File: tb/sim_rxd_dma.sv
module sim_rxd_dma;
   logic clk = 0, rst_n = 0;
   logic reg_we = 0; logic [3:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic hdr_valid = 0; logic [15:0] hdr_len = 0; logic hdr_ready;
   logic in_valid = 0; logic [7:0] in_data = 0; logic in_ready;
   logic mem_req, mem_we; logic [31:0] mem_addr, mem_wdata; logic [3:0] mem_be;
   logic mem_gnt = 0; logic [31:0] mem_rdata = 0;
   logic irq;

   rxd_dma u0 (.*);

   always #5 clk = ~clk;

   int total = 0, bad = 0;
   bit chk_en = 0, done = 0;
   logic [31:0] mem [int unsigned];
   logic [31:0] exp_m [int unsigned];
   logic [31:0] m_head [4], m_cur [4];
   bit m_cause = 0, m_mask = 0;
   int m_ofs = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] ev);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, ev);
      end
   endtask

   function automatic logic [31:0] rdm(input logic [31:0] a);
      return mem.exists(a >> 2) ? mem[a >> 2] : 32'd0;
   endfunction
   function automatic logic [31:0] rde(input logic [31:0] a);
      return exp_m.exists(a >> 2) ? exp_m[a >> 2] : 32'd0;
   endfunction

   // memory responder: grants on a repeating stall pattern
   always @(negedge clk) begin
      cyc++;
      mem_gnt = 0;
      if (mem_req && (cyc % 3 != 1)) begin
         mem_gnt = 1;
         if (mem_we) begin
            logic [31:0] w;
            w = rdm(mem_addr);
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) w[8*b +: 8] = mem_wdata[8*b +: 8];
            mem[mem_addr >> 2] = w;
         end else mem_rdata = rdm(mem_addr);
      end
   end

   // per-clock comparison against the reference model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(!(hdr_ready && in_ready), "R10 ready exclusive", {hdr_ready, in_ready}, 0);
         if (chk_en) chk(irq === (m_cause & m_mask), "R8 irq vs model", irq, m_cause & m_mask);
      end
   end

   task automatic put_desc(input logic [31:0] a, input bit own, input logic [15:0] sz,
                           input logic [31:0] bf, input logic [31:0] nx);
      logic [31:0] w [4];
      w[0] = {own, 31'h0000_0ab0}; w[1] = {sz, 16'h0}; w[2] = bf; w[3] = nx;
      for (int i = 0; i < 4; i++) begin
         mem[(a >> 2) + i] = w[i];
         exp_m[(a >> 2) + i] = w[i];
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
      chk_en = 0;
      @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 0;
      if (a == 0 && d[0]) m_cause = 0;
      if (a == 1) m_mask = d[0];
      if (a == 2) m_ofs = int'(d[1:0]);
      if (a >= 4 && a < 8) begin m_head[a-4] = d; m_cur[a-4] = d; end
      chk_en = 1;
   endtask

   task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); reg_addr = a; #1 d = reg_rdata;
   endtask

   task automatic model_frame(input int len, input logic [7:0] fd []);
      bit hit = 0;
      for (int r = 0; r < 4 && !hit; r++) begin
         logic [31:0] d, cmd, w1, bf, nx;
         if (m_cur[r] == 0) continue;
         d = m_cur[r];
         do begin
            cmd = rde(d); w1 = rde(d + 4); bf = rde(d + 8); nx = rde(d + 12);
            if (cmd[31] && int'(w1[31:16]) >= len) begin
               for (int i = 0; i < len; i++) begin
                  logic [31:0] ba, w;
                  ba = bf + m_ofs + i;
                  w = rde(ba);
                  w[8*ba[1:0] +: 8] = fd[i];
                  exp_m[ba >> 2] = w;
               end
               exp_m[(d + 4) >> 2] = {w1[31:16], 16'(len + m_ofs)};
               exp_m[d >> 2] = cmd & 32'h7fff_ffff;
               m_cur[r] = nx; m_cause = 1; hit = 1;
            end
            d = nx;
         end while (!hit && d != m_head[r]);
      end
   endtask

   task automatic frame(input int len, input int seed, input string tag);
      logic [7:0] fd [];
      int nm = 0;
      logic [31:0] v;
      fd = new[len];
      for (int i = 0; i < len; i++) fd[i] = 8'(seed + 7 * i);
      chk_en = 0;
      @(negedge clk); hdr_valid = 1; hdr_len = 16'(len);
      while (!hdr_ready) @(negedge clk);
      @(negedge clk); hdr_valid = 0;
      for (int i = 0; i < len; i++) begin
         in_valid = 1; in_data = fd[i];
         while (!in_ready) @(negedge clk);
         @(negedge clk);
      end
      in_valid = 0;
      while (!hdr_ready) @(negedge clk);
      model_frame(len, fd);
      chk_en = 1;
      foreach (exp_m[k]) if ((mem.exists(k) ? mem[k] : 32'd0) !== exp_m[k]) nm++;
      foreach (mem[k]) if (!exp_m.exists(k) && mem[k] !== 0) nm++;
      chk(nm == 0, {tag, " memory image"}, nm, 0);
      for (int r = 0; r < 4; r++) begin
         rd_reg(4'(4 + r), v);
         chk(v === m_cur[r], {tag, " ring pointer R5"}, v, m_cur[r]);
      end
      rd_reg(4'd0, v);
      chk(v === {31'd0, m_cause}, {tag, " cause R8"}, v, {31'd0, m_cause});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         done = 1;
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      for (int r = 0; r < 4; r++) begin m_head[r] = 0; m_cur[r] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R9 reset state
      for (int a = 0; a < 12; a++) begin
         rd_reg(4'(a), v);
         chk(v === 0, "R9 reset register", v, 0);
      end
      chk(irq === 0 && hdr_ready === 1 && in_ready === 0, "R10 reset handshake", {irq, hdr_ready, in_ready}, 3'b010);
      chk_en = 1;

      // R9 first-descriptor registers
      wr_reg(4'd8, 32'h1234_5670); wr_reg(4'd11, 32'hcafe_0010);
      rd_reg(4'd8, v);  chk(v === 32'h1234_5670, "R9 first reg 0", v, 32'h1234_5670);
      rd_reg(4'd11, v); chk(v === 32'hcafe_0010, "R9 first reg 3", v, 32'hcafe_0010);

      put_desc(32'h100, 1, 64, 32'h1000, 32'h110);
      put_desc(32'h110, 1, 64, 32'h1100, 32'h100);
      put_desc(32'h200, 1, 4,  32'h2000, 32'h210);
      put_desc(32'h210, 1, 32, 32'h2100, 32'h200);
      put_desc(32'h300, 1, 16, 32'h3000, 32'h310);
      put_desc(32'h310, 1, 16, 32'h3100, 32'h320);
      put_desc(32'h320, 1, 16, 32'h3200, 32'h300);
      wr_reg(4'd1, 1);
      wr_reg(4'd4, 32'h100); wr_reg(4'd6, 32'h200); wr_reg(4'd7, 32'h300);
      rd_reg(4'd6, v); chk(v === 32'h200, "R9 pointer readback", v, 32'h200);

      frame(10, 8'h11, "R1 R3 R4 first frame ring0");
      chk(irq === 1, "R8 irq after accept", irq, 1);
      wr_reg(4'd0, 0);
      chk(irq === 1, "R8 write 0 keeps cause", irq, 1);
      wr_reg(4'd0, 1);
      chk(irq === 0, "R8 W1C clears", irq, 0);
      frame(5, 8'h40, "R5 second frame wraps ring0");
      wr_reg(4'd1, 0);
      chk(irq === 0, "R8 mask off", irq, 0);
      wr_reg(4'd1, 1); wr_reg(4'd0, 1);
      frame(8, 8'h60, "R2 R3 skip ring1 small buffer ring2");
      frame(4, 8'h70, "R3 capacity equals length");
      wr_reg(4'd2, 2);
      frame(12, 8'h80, "R4 header offset ring3");
      // ring3 current is past head: revoke the rest, re-own head
      put_desc(32'h310, 0, 16, 32'h3100, 32'h320);
      put_desc(32'h320, 0, 16, 32'h3200, 32'h300);
      put_desc(32'h300, 1, 16, 32'h3000, 32'h310);
      wr_reg(4'd0, 1);
      frame(3, 8'h90, "R6 R7 walk stops at head");
      chk(irq === 0, "R7 drop leaves cause", irq, 0);
      frame(20, 8'ha0, "R7 oversize drop");
      wr_reg(4'd7, 32'h300);
      frame(0, 0, "R9 reload ring3 zero length");
      put_desc(32'h100, 1, 15, 32'h1000, 32'h110);
      put_desc(32'h110, 1, 16, 32'h1100, 32'h100);
      wr_reg(4'd2, 0);
      frame(16, 8'hb0, "R3 capacity one short rejected");
      frame(2, 8'hc0, "R11 stalled grants");

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule